// File: doc/BRIEF.md
# Power Interleaver Sequence Generator

This block builds a user-specific chip interleaver from a single stored master permutation. Only the master table is kept. The pattern for user `k` is the master permutation composed with itself `k` times. No intermediate permutation is stored, so a higher user index costs more table passes instead of more memory.

Before a run, the master table is written one entry at a time. The data can come from a host or from an external random position source. The chip buffer is written the same way. A `start` with a user index walks every chip position in ascending order. For each position, an address register is loaded with the position and then passed through the master table once per clock until the power count is reached. The resulting address is presented with a valid strobe. The chip found at that position is scattered into a reordered buffer, and the reordered buffer can be read back by position once `done` has pulsed.

Top module: `power_ileaver`

## Requirements
- R1: After reset, `busy`, `addr_valid`, `done` and `err` are low, the master table holds the identity (entry c = c), and every chip buffer entry is zero.
- R2: While idle, `tbl_we` writes `tbl_val` into master table entry `tbl_idx`. From then on, that entry is used by every later run.
- R3: A `start` while idle with `user_idx` equal to 0 or greater than `N_USERS` starts no run. Instead, `err` is high for exactly the one cycle after that edge, and `busy` stays low.
- R4: An accepted run for user k presents exactly `N_CHIPS` addresses. `addr_src` takes the values 0 to `N_CHIPS`-1 in ascending order, and each one comes with `addr_out` = Φ^k(`addr_src`), where Φ is the master table.
- R5: In a run for user k, the first `addr_valid` appears k cycles after the accepting clock edge, and consecutive `addr_valid` strobes are exactly k+1 cycles apart. `addr_valid` is never high in two consecutive cycles.
- R6: `done` is high for exactly one cycle, in the cycle right after the last `addr_valid`.
- R7: While `busy` is high, writes to the master table and to the chip buffer have no effect.
- R8: While `busy` is high, a `start` has no effect. The current run keeps its user index and timing, and `busy` stays high until `done`.
- R9: After a run for user k, `rd_data` at `rd_idx` = Φ^k(c) equals the chip written at position c.
- R10: `busy` is high from the cycle after the accepting edge through the `done` cycle, and `addr_valid` only occurs while `busy` is high.
- R11: A user index equal to `N_USERS` is accepted and produces Φ^N_USERS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Master table write strobe |
| tbl_idx | input | CW | Master table entry to write |
| tbl_val | input | CW | Position to store in that entry |
| chip_we | input | 1 | Chip buffer write strobe |
| chip_idx | input | CW | Chip position to write |
| chip_data | input | DW | Chip value |
| user_idx | input | UW | Requested power index |
| start | input | 1 | Start a run |
| busy | output | 1 | Run in progress |
| addr_valid | output | 1 | Address strobe |
| addr_src | output | CW | Chip position c being mapped |
| addr_out | output | CW | Permuted address Φ^k(c) |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Rejected user index |
| rd_idx | input | CW | Reordered buffer read position |
| rd_data | output | DW | Reordered chip at `rd_idx` |

## Verification
The assertions assume that the master table holds a true permutation of the chip positions. They also assume that reset is applied before the first `start`. The bench only loads a full permutation and always resets first. Its mid-run writes and restarts are timed to land only while the block is busy, so the protocol checks on `err`, `done` and the strobe spacing follow from the block's own sequencing.

// File: rtl/pi_pkg.sv
package pi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_EMIT = 2'd2,
        ST_DONE = 2'd3
    } pi_state_e;

    typedef struct packed {
        logic valid;
        logic [7:0] src;
        logic [7:0] dst;
    } pi_emit_t;

    function automatic int unsigned pi_clog2(input int unsigned v);
        int unsigned r;
        r = 0;
        while ((32'd1 << r) < v) r++;
        return (r == 0) ? 1 : r;
    endfunction

endpackage

// File: rtl/pi_master_table.sv
module pi_master_table #(
    parameter int N_CHIPS = 8,
    parameter int CW      = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lock,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_idx,
    input  logic [CW-1:0] wr_val,
    input  logic [CW-1:0] rd_addr,
    output logic [CW-1:0] rd_data
);
    logic [CW-1:0] perm_q [N_CHIPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CHIPS; i++) perm_q[i] <= CW'(i);
        end else if (wr_en && !lock) begin
            perm_q[wr_idx] <= wr_val;
        end
    end

    assign rd_data = perm_q[rd_addr];
endmodule

// File: rtl/pi_chip_buffer.sv
module pi_chip_buffer #(
    parameter int N_CHIPS = 8,
    parameter int CW      = 3,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lock,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          scat_en,
    input  logic [CW-1:0] scat_src,
    input  logic [CW-1:0] scat_dst,
    input  logic [CW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] in_q  [N_CHIPS];
    logic [DW-1:0] out_q [N_CHIPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CHIPS; i++) in_q[i] <= '0;
        end else if (wr_en && !lock) begin
            in_q[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CHIPS; i++) out_q[i] <= '0;
        end else if (scat_en) begin
            out_q[scat_dst] <= in_q[scat_src];
        end
    end

    assign rd_data = out_q[rd_idx];
endmodule

// File: rtl/pi_power_engine.sv
module pi_power_engine
    import pi_pkg::*;
#(
    parameter int N_CHIPS = 8,
    parameter int N_USERS = 8,
    parameter int CW      = 3,
    parameter int UW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [UW-1:0] user_idx,
    output logic [CW-1:0] tbl_addr,
    input  logic [CW-1:0] tbl_data,
    output logic          busy,
    output logic          emit_valid,
    output logic [CW-1:0] emit_src,
    output logic [CW-1:0] emit_dst,
    output logic          done,
    output logic          err
);
    localparam logic [CW-1:0] LAST_C = CW'(N_CHIPS - 1);
    localparam logic [UW-1:0] MAX_K  = UW'(N_USERS);

    pi_state_e     st_q;
    logic [CW-1:0] c_q;
    logic [CW-1:0] walk_q;
    logic [UW-1:0] k_q;
    logic [UW-1:0] cnt_q;
    logic          err_q;
    logic          k_ok;

    assign k_ok = (user_idx != '0) && (user_idx <= MAX_K);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            c_q    <= '0;
            walk_q <= '0;
            k_q    <= '0;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        if (k_ok) begin
                            k_q    <= user_idx;
                            c_q    <= '0;
                            walk_q <= '0;
                            cnt_q  <= '0;
                            st_q   <= ST_STEP;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_STEP: begin
                    walk_q <= tbl_data;
                    cnt_q  <= cnt_q + UW'(1);
                    if (cnt_q + UW'(1) == k_q) st_q <= ST_EMIT;
                end
                ST_EMIT: begin
                    if (c_q == LAST_C) begin
                        st_q <= ST_DONE;
                    end else begin
                        c_q    <= c_q + CW'(1);
                        walk_q <= c_q + CW'(1);
                        cnt_q  <= '0;
                        st_q   <= ST_STEP;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign tbl_addr   = walk_q;
    assign busy       = (st_q != ST_IDLE);
    assign emit_valid = (st_q == ST_EMIT);
    assign emit_src   = c_q;
    assign emit_dst   = walk_q;
    assign done       = (st_q == ST_DONE);
    assign err        = err_q;
endmodule

// File: rtl/power_ileaver.sv
module power_ileaver
    import pi_pkg::*;
#(
    parameter int N_CHIPS = 8,
    parameter int N_USERS = 8,
    parameter int DW      = 8,
    localparam int CW     = pi_clog2(N_CHIPS),
    localparam int UW     = pi_clog2(N_USERS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tbl_we,
    input  logic [CW-1:0] tbl_idx,
    input  logic [CW-1:0] tbl_val,
    input  logic          chip_we,
    input  logic [CW-1:0] chip_idx,
    input  logic [DW-1:0] chip_data,
    input  logic [UW-1:0] user_idx,
    input  logic          start,
    output logic          busy,
    output logic          addr_valid,
    output logic [CW-1:0] addr_src,
    output logic [CW-1:0] addr_out,
    output logic          done,
    output logic          err,
    input  logic [CW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [CW-1:0] t_addr;
    logic [CW-1:0] t_data;
    logic          eng_busy;
    logic          e_valid;
    logic [CW-1:0] e_src;
    logic [CW-1:0] e_dst;

    pi_master_table #(.N_CHIPS(N_CHIPS), .CW(CW)) u_table (
        .clk(clk), .rst(rst), .lock(eng_busy),
        .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_val(tbl_val),
        .rd_addr(t_addr), .rd_data(t_data)
    );

    pi_power_engine #(.N_CHIPS(N_CHIPS), .N_USERS(N_USERS), .CW(CW), .UW(UW)) u_engine (
        .clk(clk), .rst(rst), .start(start), .user_idx(user_idx),
        .tbl_addr(t_addr), .tbl_data(t_data), .busy(eng_busy),
        .emit_valid(e_valid), .emit_src(e_src), .emit_dst(e_dst),
        .done(done), .err(err)
    );

    pi_chip_buffer #(.N_CHIPS(N_CHIPS), .CW(CW), .DW(DW)) u_buf (
        .clk(clk), .rst(rst), .lock(eng_busy),
        .wr_en(chip_we), .wr_idx(chip_idx), .wr_data(chip_data),
        .scat_en(e_valid), .scat_src(e_src), .scat_dst(e_dst),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    assign busy       = eng_busy;
    assign addr_valid = e_valid;
    assign addr_src   = e_src;
    assign addr_out   = e_dst;
endmodule

// File: rtl/power_ileaver_chk.sv
module power_ileaver_chk #(
    parameter int CW      = 3,
    parameter int N_CHIPS = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          addr_valid,
    input logic [CW-1:0] addr_src,
    input logic          done,
    input logic          err
);
    localparam logic [CW-1:0] LAST_C = CW'(N_CHIPS - 1);

    // R5
    valid_gap_chk: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> !addr_valid);

    // R6
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(addr_valid) && $past(addr_src) == LAST_C));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(start) && !$past(busy) && !busy));

    // R10
    valid_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> busy);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

bind power_ileaver power_ileaver_chk #(.CW(CW), .N_CHIPS(N_CHIPS)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .addr_valid(addr_valid), .addr_src(addr_src), .done(done), .err(err)
);

// File: tb/power_ileaver_bench.sv
module power_ileaver_bench;
    localparam int N  = 8;
    localparam int NU = 8;
    localparam int CW = 3;
    localparam int UW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tbl_we = 1'b0;
    logic [CW-1:0] tbl_idx = '0;
    logic [CW-1:0] tbl_val = '0;
    logic          chip_we = 1'b0;
    logic [CW-1:0] chip_idx = '0;
    logic [DW-1:0] chip_data = '0;
    logic [UW-1:0] user_idx = '0;
    logic          start = 1'b0;
    logic          busy, addr_valid, done, err;
    logic [CW-1:0] addr_src, addr_out;
    logic [CW-1:0] rd_idx = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int phi  [N];
    int chip [N];

    always #10 clk = ~clk;

    power_ileaver u_power_ileaver (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_val(tbl_val),
        .chip_we(chip_we), .chip_idx(chip_idx), .chip_data(chip_data),
        .user_idx(user_idx), .start(start), .busy(busy), .addr_valid(addr_valid),
        .addr_src(addr_src), .addr_out(addr_out), .done(done), .err(err),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pw(input int c, input int k);
        int v = c;
        for (int i = 0; i < k; i++) v = phi[v];
        return v;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0, "R1 busy", int'(busy), 0);
        chk(addr_valid == 0, "R1 addr_valid", int'(addr_valid), 0);
        chk(done == 0, "R1 done", int'(done), 0);
        chk(err == 0, "R1 err", int'(err), 0);
        for (int c = 0; c < N; c++) begin
            rd_idx = CW'(c);
            #1;
            chk(rd_data == 0, "R1 buffer zero", int'(rd_data), 0);
        end
    endtask

    task automatic t_load(input bit ident);
        for (int c = 0; c < N; c++) begin
            phi[c]    = ident ? c : ((c * 5 + 3) % N);
            chip[c]   = (c * 37 + 11) & 8'hFF;
            tbl_we    = 1'b1; tbl_idx = CW'(c); tbl_val = CW'(phi[c]);
            chip_we   = 1'b1; chip_idx = CW'(c); chip_data = DW'(chip[c]);
            @(negedge clk);
        end
        tbl_we = 1'b0; chip_we = 1'b0;
    endtask

    // Run user k; when inject is set, writes and a restart are issued mid-run (R7, R8)
    task automatic t_run(input int k, input bit inject);
        int cyc = 0;
        int c = 0;
        int last = -10;
        bit got_done = 0;
        user_idx = UW'(k); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!got_done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 2) begin
                tbl_we = 1'b1; tbl_idx = '0; tbl_val = CW'(phi[0] ^ 1);
                chip_we = 1'b1; chip_idx = '0; chip_data = 8'hEE;
                start = 1'b1; user_idx = UW'(1);
            end else begin
                tbl_we = 1'b0; chip_we = 1'b0; start = 1'b0;
            end
            chk(busy == 1, "R10 busy during run", int'(busy), 1);
            if (addr_valid) begin
                chk(int'(addr_src) == c, "R4 src order", int'(addr_src), c);
                chk(int'(addr_out) == pw(c, k), (k == NU) ? "R11 max power" : "R4 addr",
                    int'(addr_out), pw(c, k));
                chk(cyc == k + c * (k + 1), "R5 strobe timing", cyc, k + c * (k + 1));
                last = cyc;
                c++;
            end
            if (done) begin
                got_done = 1;
                chk(cyc == last + 1, "R6 done position", cyc, last + 1);
            end
        end
        tbl_we = 1'b0; chip_we = 1'b0; start = 1'b0;
        chk(c == N, "R4 address count", c, N);
        @(negedge clk);
        chk(done == 0 && busy == 0, "R6 done one cycle", int'(done), 0);
        for (int i = 0; i < N; i++) begin
            rd_idx = CW'(pw(i, k));
            #1;
            chk(int'(rd_data) == chip[i], "R9 reorder", int'(rd_data), chip[i]);
        end
    endtask

    task automatic t_bad(input int k);
        user_idx = UW'(k); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1, "R3 err pulse", int'(err), 1);
        chk(busy == 0, "R3 no run", int'(busy), 0);
        @(negedge clk);
        chk(err == 0, "R3 err one cycle", int'(err), 0);
        chk(busy == 0 && addr_valid == 0, "R3 stays idle", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        for (int c = 0; c < N; c++) begin phi[c] = c; chip[c] = 0; end
        t_run(1, 0);          // R1 identity table after reset
        t_load(0);            // R2
        t_run(1, 0);
        t_run(3, 0);
        t_run(2, 1);          // R7 R8 injected while busy
        t_run(1, 0);          // R7 table and chips unchanged
        t_run(NU, 0);         // R11
        t_bad(0);             // R3
        t_bad(NU + 1);        // R3
        t_run(5, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule